// File: doc/BRIEF.md
# Segment-Controlled Address Decoder

This block classifies every 32-bit virtual address before any translation lookup is attempted. The address space is cut into six fixed regions. Each region is governed by its own 16-bit configuration field, and the fields are packed two per register into three 32-bit segment control inputs. The access-mode code in a field, combined with the current execution mode, decides the outcome of the access. It is either an address error, a lookup in the translation buffer, or a direct-mapped access. For a direct-mapped access the block also forms the physical address from the field's base bits.

The block sits between address generation and the translation buffer. Its three results are registered, so they appear one clock after the inputs are presented. The translation buffer itself is not part of this block.

Top module: `seg_decoder`

## Requirements
- R1: While rst_ni is low, and after it is released and before the first clock edge, addr_err_o = 0, tlb_map_o = 0 and paddr_o = 0.
- R2: The region is picked by the address as follows:
  - below 0x40000000 uses segctl2_i[31:16], and 0x40000000–0x7FFFFFFF uses segctl2_i[15:0];
  - 0x80000000–0x9FFFFFFF uses segctl1_i[31:16], and 0xA0000000–0xBFFFFFFF uses segctl1_i[15:0];
  - 0xC0000000–0xDFFFFFFF uses segctl0_i[31:16], and 0xE0000000 and above uses segctl0_i[15:0].
- R3: Within a 16-bit field, bits [2:0] are the access-mode code, bit 3 is the error-level override, and bits [15:9] are the base. When bit 3 is 1 and erl_i is 1, the access is direct-mapped with no error, whatever the code and the mode.
- R4: The mode encoding is 0 kernel, 1 supervisor, 2 user. In kernel mode (mode_i = 0) no code except 6 gives an error, and codes 1, 2 and 3 go to the translation buffer.
- R5: In supervisor mode (mode_i = 1), codes 0 and 1 give an error (as does 6), and codes 2, 3 and 4 go to the translation buffer.
- R6: In user mode (mode_i = 2), codes 0, 1, 2 and 5 give an error (as does 6), and codes 3 and 4 go to the translation buffer.
- R7: Code 6 and mode_i = 3 are reserved and give an address error, unless the R3 override applies.
- R8: A direct-mapped access has paddr_o = (((base << 29) truncated to 32 bits) AND NOT mask) OR (address AND mask). Here base is field[15:9], and mask is 0x3FFFFFFF below 0x80000000 and 0x1FFFFFFF from 0x80000000 upward.
- R9: addr_err_o and tlb_map_o are never both 1. Whenever either is 1, paddr_o = 0.
- R10: Outputs reflect the inputs sampled at the previous rising clock edge and do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vaddr_i | input | 32 | Virtual address |
| mode_i | input | 2 | Execution mode: 0 kernel, 1 supervisor, 2 user, 3 reserved |
| erl_i | input | 1 | Error-level flag |
| segctl0_i | input | 32 | Segment control for the two top regions |
| segctl1_i | input | 32 | Segment control for the two middle kernel regions |
| segctl2_i | input | 32 | Segment control for the two user regions |
| addr_err_o | output | 1 | Access is an address error |
| tlb_map_o | output | 1 | Access must be looked up in the translation buffer |
| paddr_o | output | 32 | Physical address for a direct-mapped access, else 0 |

## Verification
The sweep crosses every access-mode code with every execution mode and both states of the override and error-level bits, in all six regions. The five unused field halves are filled with a reserved code, so a decoder that reads the wrong half reports a spurious address error. Region edges such as 0x3FFFFFFF/0x40000000 and 0x9FFFFFFF/0xA0000000 are hit directly, which exposes an off-by-one comparison as a wrong base in the physical address. The user mask of 0x3FFFFFFF against the kernel mask of 0x1FFFFFFF shows up as a corrupted bit 29. An override that also needs a non-error code, instead of winning outright, shows up as faults in the reserved-code cases.

// File: rtl/seg_dec_pkg.sv
package seg_dec_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned FIELD_W  = 16;
  localparam int unsigned AM_W     = 3;
  localparam int unsigned EU_BIT   = 3;
  localparam int unsigned BASE_LSB = 9;
  localparam int unsigned PA_SHIFT = 20;
  localparam int unsigned N_SEG    = 6;
  localparam int unsigned N_CODE   = 1 << AM_W;

  typedef enum logic [1:0] {
    MODE_KERN = 2'd0,
    MODE_SUPV = 2'd1,
    MODE_USER = 2'd2,
    MODE_RSVD = 2'd3
  } exec_mode_e;

  typedef logic [FIELD_W-1:0] seg_field_t;
endpackage

// File: rtl/seg_field_sel.sv
module seg_field_sel
  import seg_dec_pkg::*;
#(
  parameter logic [ADDR_W-1:0] USER_MASK = 32'h3FFF_FFFF,
  parameter logic [ADDR_W-1:0] KERN_MASK = 32'h1FFF_FFFF
) (
  input  logic [2:0]        vtop_i,
  input  logic [ADDR_W-1:0] ctl0_i,
  input  logic [ADDR_W-1:0] ctl1_i,
  input  logic [ADDR_W-1:0] ctl2_i,
  output seg_field_t        field_o,
  output logic [ADDR_W-1:0] mask_o
);
  localparam int unsigned IDX_W = $clog2(N_SEG);

  seg_field_t       pool [N_SEG];
  logic [IDX_W-1:0] idx;

  // pool order: user low, user high, then the four kernel regions by address
  genvar g;
  generate
    for (g = 0; g < N_SEG; g++) begin : g_pool
      localparam int unsigned REG  = 2 - (g / 2);
      localparam int unsigned HALF = 1 - (g % 2);
      if (REG == 2) begin : g_r2
        assign pool[g] = ctl2_i[HALF*FIELD_W +: FIELD_W];
      end else if (REG == 1) begin : g_r1
        assign pool[g] = ctl1_i[HALF*FIELD_W +: FIELD_W];
      end else begin : g_r0
        assign pool[g] = ctl0_i[HALF*FIELD_W +: FIELD_W];
      end
    end
  endgenerate

  always_comb begin
    if (!vtop_i[2]) begin
      idx    = vtop_i[1] ? IDX_W'(1) : IDX_W'(0);
      mask_o = USER_MASK;
    end else begin
      idx    = IDX_W'(2) + IDX_W'(vtop_i[1:0]);
      mask_o = KERN_MASK;
    end
  end

  assign field_o = pool[idx];
endmodule

// File: rtl/seg_access_policy.sv
module seg_access_policy
  import seg_dec_pkg::*;
(
  input  logic [AM_W-1:0] am_i,
  input  logic            eu_i,
  input  logic            erl_i,
  input  logic [1:0]      mode_i,
  output logic            bad_o,
  output logic            tlb_o
);
  // bit n set: code n takes the action
  localparam logic [N_CODE-1:0] KERN_ERR = 8'b0100_0000;
  localparam logic [N_CODE-1:0] KERN_TLB = 8'b0000_1110;
  localparam logic [N_CODE-1:0] SUPV_ERR = 8'b0100_0011;
  localparam logic [N_CODE-1:0] SUPV_TLB = 8'b0001_1100;
  localparam logic [N_CODE-1:0] USER_ERR = 8'b0110_0111;
  localparam logic [N_CODE-1:0] USER_TLB = 8'b0001_1000;

  logic [N_CODE-1:0] err_tab, tlb_tab;
  logic              force_direct;

  always_comb begin
    unique case (exec_mode_e'(mode_i))
      MODE_KERN: begin err_tab = KERN_ERR; tlb_tab = KERN_TLB; end
      MODE_SUPV: begin err_tab = SUPV_ERR; tlb_tab = SUPV_TLB; end
      MODE_USER: begin err_tab = USER_ERR; tlb_tab = USER_TLB; end
      default:   begin err_tab = '1;       tlb_tab = '0;       end
    endcase
  end

  assign force_direct = eu_i & erl_i;
  assign bad_o = ~force_direct & err_tab[am_i];
  assign tlb_o = ~force_direct & ~err_tab[am_i] & tlb_tab[am_i];
endmodule

// File: rtl/seg_paddr.sv
module seg_paddr
  import seg_dec_pkg::*;
(
  input  seg_field_t        field_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic [ADDR_W-1:0] mask_i,
  input  logic              direct_i,
  output logic [ADDR_W-1:0] paddr_o
);
  localparam int unsigned EXT_W = FIELD_W + PA_SHIFT;
  localparam seg_field_t  BASE_MASK = seg_field_t'(~((1 << BASE_LSB) - 1));

  logic [EXT_W-1:0]  ext;
  logic [ADDR_W-1:0] base;

  assign ext     = {field_i & BASE_MASK, {PA_SHIFT{1'b0}}};
  assign base    = ext[ADDR_W-1:0];
  assign paddr_o = direct_i ? ((base & ~mask_i) | (vaddr_i & mask_i)) : '0;
endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
  import seg_dec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic [1:0]        mode_i,
  input  logic              erl_i,
  input  logic [ADDR_W-1:0] segctl0_i,
  input  logic [ADDR_W-1:0] segctl1_i,
  input  logic [ADDR_W-1:0] segctl2_i,
  output logic              addr_err_o,
  output logic              tlb_map_o,
  output logic [ADDR_W-1:0] paddr_o
);
  seg_field_t        sel_field;
  logic [ADDR_W-1:0] sel_mask;
  logic              bad_c, tlb_c;
  logic [ADDR_W-1:0] pa_c;

  seg_field_sel u_sel (
    .vtop_i  (vaddr_i[ADDR_W-1 -: 3]),
    .ctl0_i  (segctl0_i),
    .ctl1_i  (segctl1_i),
    .ctl2_i  (segctl2_i),
    .field_o (sel_field),
    .mask_o  (sel_mask)
  );

  seg_access_policy u_pol (
    .am_i   (sel_field[AM_W-1:0]),
    .eu_i   (sel_field[EU_BIT]),
    .erl_i  (erl_i),
    .mode_i (mode_i),
    .bad_o  (bad_c),
    .tlb_o  (tlb_c)
  );

  seg_paddr u_pa (
    .field_i  (sel_field),
    .vaddr_i  (vaddr_i),
    .mask_i   (sel_mask),
    .direct_i (~bad_c & ~tlb_c),
    .paddr_o  (pa_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_err_o <= 1'b0;
      tlb_map_o  <= 1'b0;
      paddr_o    <= '0;
    end else begin
      addr_err_o <= bad_c;
      tlb_map_o  <= tlb_c;
      paddr_o    <= pa_c;
    end
  end
endmodule

// File: rtl/seg_decoder_chk.sv
module seg_decoder_chk
  import seg_dec_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic              erl_i,
  input logic [AM_W-1:0]   am_i,
  input logic              eu_i,
  input logic              addr_err_o,
  input logic              tlb_map_o,
  input logic [ADDR_W-1:0] paddr_o
);
  logic primed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed <= 1'b0;
    else         primed <= 1'b1;
  end

  assert_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(addr_err_o && tlb_map_o));

  assert_pa_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_err_o || tlb_map_o) |-> (paddr_o == '0));

  assert_override_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(eu_i && erl_i) |-> (!addr_err_o && !tlb_map_o));

  assert_kern_no_err_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(mode_i == 2'd0 && am_i != 3'd6 && !(eu_i && erl_i)) |-> !addr_err_o);

  assert_user_tlb_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(mode_i == 2'd2 && (am_i == 3'd3 || am_i == 3'd4) && !(eu_i && erl_i))
    |-> tlb_map_o);

  assert_reserved_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past((am_i == 3'd6 || mode_i == 2'd3) && !(eu_i && erl_i)) |-> addr_err_o);
endmodule

bind seg_decoder seg_decoder_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .erl_i      (erl_i),
  .am_i       (sel_field[2:0]),
  .eu_i       (sel_field[3]),
  .addr_err_o (addr_err_o),
  .tlb_map_o  (tlb_map_o),
  .paddr_o    (paddr_o)
);

// File: tb/tb_seg_decoder.sv
module tb_seg_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] vaddr_i = '0;
  logic [1:0]  mode_i = '0;
  logic        erl_i = 1'b0;
  logic [31:0] segctl0_i = '0, segctl1_i = '0, segctl2_i = '0;
  logic        addr_err_o, tlb_map_o;
  logic [31:0] paddr_o;

  int errors = 0;
  int checks = 0;

  always #5 clk_i = ~clk_i;

  seg_decoder dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .vaddr_i(vaddr_i), .mode_i(mode_i),
    .erl_i(erl_i), .segctl0_i(segctl0_i), .segctl1_i(segctl1_i),
    .segctl2_i(segctl2_i), .addr_err_o(addr_err_o), .tlb_map_o(tlb_map_o),
    .paddr_o(paddr_o)
  );

  function automatic logic [33:0] model(input logic [31:0] a, input logic [1:0] m,
      input logic e, input logic [31:0] c0, input logic [31:0] c1, input logic [31:0] c2);
    logic [15:0] f;
    logic [31:0] msk, pa;
    logic bad, tlb;
    int am;
    if (a <= 32'h7FFF_FFFF) begin
      f = (a >= 32'h4000_0000) ? c2[15:0] : c2[31:16];
      msk = 32'h3FFF_FFFF;
    end else begin
      msk = 32'h1FFF_FFFF;
      if (a < 32'hA000_0000)      f = c1[31:16];
      else if (a < 32'hC000_0000) f = c1[15:0];
      else if (a < 32'hE000_0000) f = c0[31:16];
      else                        f = c0[15:0];
    end
    am = int'(f[2:0]);
    bad = 1'b0; tlb = 1'b0;
    if (!(f[3] && e)) begin
      if (m == 2'd3 || am == 6) bad = 1'b1;
      else if (m == 2'd0) tlb = (am >= 1 && am <= 3);
      else if (m == 2'd1) begin bad = (am <= 1); tlb = (am >= 2 && am <= 4); end
      else begin bad = (am <= 2 || am == 5); tlb = (am == 3 || am == 4); end
    end
    pa = '0;
    if (!bad && !tlb) pa = ((32'(f[15:9]) << 29) & ~msk) | (a & msk);
    return {bad, tlb, pa};
  endfunction

  task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got err=%b tlb=%b pa=%h, expected err=%b tlb=%b pa=%h",
               tag, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // apply at negedge, check at the following negedge (one register stage)
  task automatic run_vec(input string tag, input logic [31:0] a, input logic [1:0] m,
      input logic e, input logic [31:0] c0, input logic [31:0] c1, input logic [31:0] c2);
    vaddr_i = a; mode_i = m; erl_i = e;
    segctl0_i = c0; segctl1_i = c1; segctl2_i = c2;
    @(negedge clk_i);
    check(tag, {addr_err_o, tlb_map_o, paddr_o}, model(a, m, e, c0, c1, c2));
  endtask

  initial begin
    #(10 * 190000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] bases [6];
    logic [31:0] spans [6];
    bases = '{32'h0, 32'h4000_0000, 32'h8000_0000, 32'hA000_0000, 32'hC000_0000, 32'hE000_0000};
    spans = '{32'h3FFF_FFFF, 32'h3FFF_FFFF, 32'h1FFF_FFFF, 32'h1FFF_FFFF, 32'h1FFF_FFFF, 32'h1FFF_FFFF};

    // R1 reset with busy inputs
    vaddr_i = 32'hA123_4567; segctl1_i = 32'hFFF7_FFF7; erl_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 reset", {addr_err_o, tlb_map_o, paddr_o}, 34'd0);
    rst_ni = 1'b1;
    #1;
    check("R1 after release", {addr_err_o, tlb_map_o, paddr_o}, 34'd0);
    @(negedge clk_i);

    // R10: outputs hold until the next edge
    vaddr_i = 32'h2000_0000; mode_i = 2'd0; erl_i = 1'b0;
    segctl0_i = '0; segctl1_i = '0; segctl2_i = 32'h0006_0006;
    @(negedge clk_i);
    check("R10 settle", {addr_err_o, tlb_map_o, paddr_o}, {1'b1, 1'b0, 32'h0});
    segctl2_i = 32'h0007_0007;
    #2;
    check("R10 hold before edge", {addr_err_o, tlb_map_o, paddr_o}, {1'b1, 1'b0, 32'h0});
    @(negedge clk_i);
    check("R10 update after edge", {addr_err_o, tlb_map_o, paddr_o},
          model(32'h2000_0000, 2'd0, 1'b0, 32'h0, 32'h0, 32'h0007_0007));

    // full sweep: mode x code x override x erl x region
    for (int m = 0; m < 4; m++)
      for (int am = 0; am < 8; am++)
        for (int eu = 0; eu < 2; eu++)
          for (int e = 0; e < 2; e++)
            for (int r = 0; r < 6; r++) begin
              int k;
              logic [15:0] f, junk;
              logic [15:0] h [6];
              logic [31:0] a;
              string tag;
              k = (((m * 8 + am) * 2 + eu) * 2 + e) * 6 + r;
              f = {7'(k) ^ 7'h5A, 5'(k * 3), 1'(eu), 3'(am)};
              junk = {~f[15:4], 4'b0110};
              for (int j = 0; j < 6; j++) h[j] = (j == r) ? f : junk;
              a = bases[r] | (32'(k) * 32'h9E37_79B1 & spans[r]);
              if (eu == 1 && e == 1)     tag = "R3 override";
              else if (am == 6 || m == 3) tag = "R7 reserved";
              else if (m == 0)           tag = "R4 kernel";
              else if (m == 1)           tag = "R5 supervisor";
              else                       tag = "R6 user";
              run_vec(tag, a, 2'(m), 1'(e), {h[4], h[5]}, {h[2], h[3]}, {h[0], h[1]});
              // R8 / R9: address result for this case
              check((addr_err_o || tlb_map_o) ? "R9 pa zero" : "R8 pa form",
                    {addr_err_o, tlb_map_o, paddr_o}, model(a, 2'(m), 1'(e),
                    {h[4], h[5]}, {h[2], h[3]}, {h[0], h[1]}));
            end

    // R2: region edges, direct-mapped code 7, distinct base per half
    begin
      logic [31:0] edges [12];
      edges = '{32'h0000_0000, 32'h3FFF_FFFF, 32'h4000_0000, 32'h7FFF_FFFF,
                32'h8000_0000, 32'h9FFF_FFFF, 32'hA000_0000, 32'hBFFF_FFFF,
                32'hC000_0000, 32'hDFFF_FFFF, 32'hE000_0000, 32'hFFFF_FFFF};
      for (int i = 0; i < 12; i++)
        run_vec("R2 region edge", edges[i], 2'd0, 1'b0,
                32'h0A07_0C07, 32'h0607_0807, 32'h0207_0407);
      for (int i = 0; i < 12; i++)
        run_vec("R2 region edge user", edges[i], 2'd2, 1'b1,
                32'h0E0F_0C0F, 32'h0A0F_080F, 32'h060F_040F);
    end

    finish_run();
  end
endmodule